// File: doc/BRIEF.md
# Machine Clock Mode Switch Controller

This block decides which clock drives the machine clock. One candidate is the main clock, which the block makes by halving the oscillator. The other is one of four multiplied clocks that arrive from outside. Software sees three fields. A requested-mode bit asks for a mode: 1 means main and 0 means multiplied. A read-only monitor bit shows the mode that is actually in effect. A 2-bit code picks the multiplication factor.

The two directions of a switch do not behave the same way. Entering the multiplied mode first waits for a stabilization count of 2^STAB_LOG2 rising edges of the oscillator. Leaving it waits for the first moment at which the multiplied and main clocks line up. Both directions then move the multiplexer select only at a safe point, so the machine clock output never carries a runt pulse. The monitor bit follows the select, which means it lags the request until the switch has actually happened.

All logic runs on a fast sampling clock `clk`. The oscillator and the multiplied clocks are treated as level inputs sampled by that clock. Every pin is a plain control or status pin. No data stream passes through the block, so it has no valid/ready handshake and nothing can apply back-pressure.

Top module: `mclk_switch_ctrl`

## Requirements
- R1: After reset: mcs_rd=1, mcm_rd=1, cs_rd=00, clk_sel=1 (main) and pll_en=0.
- R2: main_clk toggles once for every rising edge of osc_in, so it runs at half the oscillator rate. While clk_sel=1, mclk_out equals main_clk. While pll_en=0, clk_sel=1.
- R3: In multiplied mode (clk_sel=0), mclk_out equals pll_in[k], where k is the value of cs_rd (00 to 11).
- R4: Writing mcs=0 while mcs_rd=1 does three things: mcs_rd becomes 0 and pll_en becomes 1 at the write edge. clk_sel and mcm_rd stay 1 until 2^STAB_LOG2 rising edges of osc_in have been counted after the write, and they fall at the first safe point after that.
- R5: Writing mcs=1 while mcs_rd=0 makes clk_sel and mcm_rd return to 1 at the first safe point. pll_en falls at that same edge.
- R6: A safe point is a clock edge at which main_clk is low and the selected pll_in has just fallen (it was high at the previous edge and is low now). clk_sel changes only at a safe point.
- R7: mcm_rd always equals clk_sel. It changes only when a pending switch completes.
- R8: A write to mcs while a switch is pending is ignored. mcs_rd keeps its value and the pending switch still completes on its original schedule.
- R9: Writing the value that mcs_rd already holds starts no transition. pll_en and clk_sel keep their values.
- R10: A write to cs takes effect only in idle main mode (mcm_rd=1 with no switch pending). At all other times it is ignored and cs_rd keeps its value.
- R11: The stabilization count restarts from zero on every accepted request for multiplied mode. It advances only while that switch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Oscillator level |
| pll_in | input | 4 | Levels of the four multiplied clocks, indexed by multiplier code |
| mcs_we | input | 1 | Write strobe for the mode request bit |
| mcs_wd | input | 1 | Mode request write data (1 = main, 0 = multiplied) |
| cs_we | input | 1 | Write strobe for the multiplier code |
| cs_wd | input | 2 | Multiplier code write data |
| mcs_rd | output | 1 | Current mode request bit |
| mcm_rd | output | 1 | Monitor bit: 1 when the main clock is in use |
| cs_rd | output | 2 | Current multiplier code |
| pll_en | output | 1 | Enables the multiplied clock path |
| clk_sel | output | 1 | Multiplexer select: 1 = main clock, 0 = multiplied clock |
| main_clk | output | 1 | Oscillator divided by two |
| mclk_out | output | 1 | Selected machine clock level |

## Verification
The hardest case to reach from the ports is a write to the request bit that arrives while a switch is still waiting. The request must be ignored, and the stabilization wait must neither restart nor abort. To reach it, the stimulus issues a contrary write partway through the stabilization wait and then checks that the completion latency still falls inside the normal window. Safe points depend on the phase between the main clock and the multiplied clocks. The bench therefore runs each multiplied clock with its own half-period, which sweeps the phase relation and lets every switch find its safe point at a different place.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_MAIN    = 3'd0,
    ST_STAB    = 3'd1,
    ST_TO_PLL  = 3'd2,
    ST_PLL     = 3'd3,
    ST_TO_MAIN = 3'd4
  } sw_state_e;
endpackage

// File: rtl/osc_div2.sv
module osc_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic osc_rise,
  output logic main_ph
);
  logic osc_q;

  assign osc_rise = osc_in & ~osc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q   <= 1'b0;
      main_ph <= 1'b0;
    end else begin
      osc_q <= osc_in;
      if (osc_rise) main_ph <= ~main_ph;
    end
  end

  // R2
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_rise |=> $stable(main_ph));
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int unsigned STAB_LOG2 = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam logic [STAB_LOG2-1:0] LAST = {STAB_LOG2{1'b1}};
  logic [STAB_LOG2-1:0] cnt;

  assign done = run & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end

  // R11
  stab_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/edge_align.sv
module edge_align #(
  parameter int unsigned MUL_W = 2,
  localparam int unsigned NUM_MUL = 1 << MUL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MUL-1:0] pll_in,
  input  logic [MUL_W-1:0]   code,
  input  logic               main_ph,
  output logic               pll_ph,
  output logic               safe
);
  logic pll_q;

  assign pll_ph = pll_in[code];
  assign safe   = pll_q & ~pll_ph & ~main_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pll_q <= 1'b0;
    else        pll_q <= pll_ph;
  end
endmodule

// File: rtl/mclk_switch_ctrl.sv
module mclk_switch_ctrl
  import mcs_pkg::*;
#(
  parameter int unsigned STAB_LOG2 = 14,
  parameter int unsigned MUL_W     = 2,
  localparam int unsigned NUM_MUL  = 1 << MUL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_in,
  input  logic [NUM_MUL-1:0] pll_in,
  input  logic               mcs_we,
  input  logic               mcs_wd,
  input  logic               cs_we,
  input  logic [MUL_W-1:0]   cs_wd,
  output logic               mcs_rd,
  output logic               mcm_rd,
  output logic [MUL_W-1:0]   cs_rd,
  output logic               pll_en,
  output logic               clk_sel,
  output logic               main_clk,
  output logic               mclk_out
);
  sw_state_e        st;
  logic             mcs_q, sel_q;
  logic [MUL_W-1:0] cs_q;
  logic             osc_rise, main_ph, pll_ph, safe, stab_done;
  logic             idle, accept, stab_clr;

  osc_div2 u_div (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
    .osc_rise(osc_rise), .main_ph(main_ph)
  );

  stab_timer #(.STAB_LOG2(STAB_LOG2)) u_stab (
    .clk(clk), .rst_n(rst_n), .clr(stab_clr), .run(st == ST_STAB),
    .tick(osc_rise), .done(stab_done)
  );

  edge_align #(.MUL_W(MUL_W)) u_align (
    .clk(clk), .rst_n(rst_n), .pll_in(pll_in), .code(cs_q),
    .main_ph(main_ph), .pll_ph(pll_ph), .safe(safe)
  );

  assign idle     = (st == ST_MAIN) || (st == ST_PLL);
  assign accept   = mcs_we && idle && (mcs_wd != mcs_q);
  assign stab_clr = accept && (st == ST_MAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_MAIN;
      mcs_q <= 1'b1;
      sel_q <= 1'b1;
      cs_q  <= '0;
    end else begin
      if (cs_we && st == ST_MAIN) cs_q <= cs_wd;
      if (accept) mcs_q <= mcs_wd;
      unique case (st)
        ST_MAIN:    if (accept) st <= ST_STAB;
        ST_STAB:    if (stab_done) st <= ST_TO_PLL;
        ST_TO_PLL:  if (safe) begin sel_q <= 1'b0; st <= ST_PLL; end
        ST_PLL:     if (accept) st <= ST_TO_MAIN;
        ST_TO_MAIN: if (safe) begin sel_q <= 1'b1; st <= ST_MAIN; end
        default:    st <= ST_MAIN;
      endcase
    end
  end

  assign mcs_rd   = mcs_q;
  assign mcm_rd   = sel_q;
  assign cs_rd    = cs_q;
  assign clk_sel  = sel_q;
  assign pll_en   = (st != ST_MAIN);
  assign main_clk = main_ph;
  assign mclk_out = sel_q ? main_ph : pll_ph;

  // R6
  sel_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> (!$past(main_ph) && !$past(pll_ph)));

  // R7
  mcm_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> ($past(st) == ST_TO_PLL || $past(st) == ST_TO_MAIN));

  // R8
  pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcs_we && !idle) |=> $stable(mcs_q));

  // R10
  cs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_we && st != ST_MAIN) |=> $stable(cs_q));

  // R2
  off_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> sel_q);
endmodule

// File: tb/sim_mclk_switch_ctrl.sv
`timescale 1ns/100ps
module sim_mclk_switch_ctrl;
  localparam int SL2 = 5;
  localparam int STAB_CLK = (1 << SL2) * 8;
  // vector: [3:2] multiplier code, [1:0] stray code written in multiplied mode
  localparam logic [3:0] VEC [4] = '{4'b0011, 4'b0110, 4'b1000, 4'b1101};
  localparam int HALF [4] = '{6, 4, 3, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_in = 1'b0;
  logic [3:0] pll_in = 4'b0;
  logic mcs_we = 1'b0, mcs_wd = 1'b1, cs_we = 1'b0;
  logic [1:0] cs_wd = 2'b00;
  logic mcs_rd, mcm_rd, pll_en, clk_sel, main_clk, mclk_out;
  logic [1:0] cs_rd;
  int total = 0, fails = 0;
  int oc = 0;
  int pc [4] = '{0, 1, 2, 0};
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (oc == 3) begin oc <= 0; osc_in <= ~osc_in; end else oc <= oc + 1;
    for (int k = 0; k < 4; k++) begin
      if (pc[k] >= HALF[k] - 1) begin pc[k] <= 0; pll_in[k] <= ~pll_in[k]; end
      else pc[k] <= pc[k] + 1;
    end
  end

  mclk_switch_ctrl #(.STAB_LOG2(SL2)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .pll_in(pll_in),
    .mcs_we(mcs_we), .mcs_wd(mcs_wd), .cs_we(cs_we), .cs_wd(cs_wd),
    .mcs_rd(mcs_rd), .mcm_rd(mcm_rd), .cs_rd(cs_rd), .pll_en(pll_en),
    .clk_sel(clk_sel), .main_clk(main_clk), .mclk_out(mclk_out)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mcs(input logic v);
    mcs_we = 1'b1; mcs_wd = v; step(); mcs_we = 1'b0;
  endtask

  task automatic wr_cs(input logic [1:0] v);
    cs_we = 1'b1; cs_wd = v; step(); cs_we = 1'b0;
  endtask

  task automatic go_pll(input bit poke, input logic [1:0] code, output int lat);
    wr_mcs(1'b0);
    lat = 0;
    chk(pll_en == 1'b1 && mcs_rd == 1'b0, "R4 pll_en/mcs_rd at write", {pll_en, mcs_rd}, 2);
    chk(mcm_rd == 1'b1, "R4 mcm held at write", mcm_rd, 1);
    while (mcm_rd && lat < 1000) begin
      if (poke && lat == 100) begin
        wr_mcs(1'b1);
        chk(mcs_rd == 1'b0, "R8 pending write ignored", mcs_rd, 0);
      end else step();
      lat++;
    end
    chk(pll_in[code] == 1'b0, "R6 pll low at select change", pll_in[code], 0);
    chk(lat >= STAB_CLK - 7 && lat <= STAB_CLK + 100, "R4 stabilization latency", lat, STAB_CLK);
    chk(clk_sel == mcm_rd, "R7 monitor equals select", mcm_rd, clk_sel);
  endtask

  task automatic go_main(input logic [1:0] code, output int lat);
    wr_mcs(1'b1);
    lat = 0;
    chk(mcm_rd == 1'b0, "R7 monitor lags request", mcm_rd, 0);
    while (!mcm_rd && lat < 1000) begin step(); lat++; end
    chk(lat >= 1 && lat <= 100, "R5 return latency", lat, 50);
    chk(pll_en == 1'b0, "R5 pll_en off", pll_en, 0);
    chk(pll_in[code] == 1'b0, "R6 pll low at return", pll_in[code], 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int lat, first_lat, bad, rises, togs;
    logic po, pm;
    repeat (3) step();
    // R1
    chk(mcs_rd && mcm_rd && clk_sel && !pll_en && cs_rd == 2'b00, "R1 reset state",
        {mcs_rd, mcm_rd, clk_sel, pll_en, cs_rd}, 6'b111000);
    rst_n = 1'b1;
    step();
    // R2 divide by two
    rises = 0; togs = 0; po = osc_in; pm = main_clk; bad = 0;
    for (int i = 0; i < 64; i++) begin
      step();
      if (osc_in && !po) rises++;
      if (main_clk != pm) togs++;
      if (mclk_out != main_clk) bad++;
      po = osc_in; pm = main_clk;
    end
    chk(rises > 4 && (togs - rises) <= 1 && (rises - togs) <= 1, "R2 main_clk half rate", togs, rises);
    chk(bad == 0, "R2 mclk_out follows main_clk", bad, 0);
    // R9 same value in main
    wr_mcs(1'b1);
    bad = 0;
    for (int i = 0; i < 8; i++) begin step(); if (pll_en || !clk_sel) bad++; end
    chk(bad == 0, "R9 duplicate write in main", bad, 0);

    first_lat = 0;
    for (int v = 0; v < 4; v++) begin
      logic [1:0] code, stray;
      code = VEC[v][3:2]; stray = VEC[v][1:0];
      wr_cs(code);
      chk(cs_rd == code, "R10 cs write in main", cs_rd, code);
      go_pll(v == 0, code, lat);
      if (v == 0) first_lat = lat;
      else chk(lat - first_lat <= 70 && first_lat - lat <= 70, "R11 count restarts", lat, first_lat);
      bad = 0;
      for (int i = 0; i < 30; i++) begin step(); if (mclk_out != pll_in[code]) bad++; end
      chk(bad == 0, "R3 mclk_out follows selected pll", bad, 0);
      wr_cs(stray);
      chk(cs_rd == code, "R10 cs write ignored", cs_rd, code);
      bad = 0;
      for (int i = 0; i < 20; i++) begin step(); if (mclk_out != pll_in[code]) bad++; end
      chk(bad == 0, "R10 live clock unchanged", bad, 0);
      if (v == 1) begin
        wr_mcs(1'b0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin step(); if (clk_sel || !pll_en) bad++; end
        chk(bad == 0, "R9 duplicate write in multiplied", bad, 0);
      end
      go_main(code, lat);
      bad = 0;
      for (int i = 0; i < 16; i++) begin step(); if (mclk_out != main_clk) bad++; end
      chk(bad == 0, "R2 main restored", bad, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule